// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a Clause 22 management master for talking to an Ethernet PHY. Software builds one 32-bit command word and writes it through a strobe. The block sends a 32-bit preamble of ones, then shifts the whole word out most significant bit first on the MDIO pad, one bit per MDC period. The word carries the start code, opcode, PHY address, register address, turnaround code and write data. MDC is a divided copy of the core clock.

Software polls an idle flag to find out when the port can take a new command and when the current frame has finished. On a read, the block releases the MDIO pad for the turnaround and data bits. It then samples the sixteen data bits returned by the PHY into the low half of the same register, which software reads back. Commands are accepted only while the port enable is high and the port is idle.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the idle flag is 1, MDC is 0, the MDIO output enable is 0 and the readback word is 0.
- R2: An accepted command produces a 64-bit frame of 32 ones followed by command bits 31 down to 0, one bit per MDC period. MDIO changes only while MDC is low, so each bit is stable across the rising MDC edge.
- R3: When command bits 29:28 are anything other than 10 (write is 01), the output enable stays high for all 64 bit periods.
- R4: When command bits 29:28 equal 10 (read), the block drives the frame up to and including the register address field in bits 22:18. It deasserts the output enable for the last 18 bit periods (turnaround bits 17:16 and the data).
- R5: On a read, the block samples MDIO on the rising MDC edge of each of the last 16 bit periods, first bit to readback bit 15. It places the result in readback bits 15:0 and leaves readback bits 31:16 equal to the command.
- R6: The idle flag falls in the cycle after an accepted write strobe and stays low for exactly 64 × D clock cycles, where D is the MDC division ratio. MDC is high for D/2 cycles and low for D/2 cycles of each period.
- R7: The division select input picks D: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 48.
- R8: A write strobe while the idle flag is low is ignored. It changes neither the frame on the pads nor the readback word nor the busy duration.
- R9: While the port enable is low, a write strobe is ignored. A frame in progress freezes with MDC held and resumes where it stopped when the enable returns.
- R10: After a write frame completes, the readback word equals the command word that was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, divided down to make MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC division select |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Readback word; read data in bits 15:0 after a read |
| mgmt_idle | output | 1 | High when the port can take a command |
| mdc | output | 1 | Management clock to the pad |
| mdio_o | output | 1 | MDIO output data to the pad |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The embedded assertions check, on every cycle, several pad rules. MDIO never changes while MDC is high. MDC and the output enable are low whenever the port is idle. The output enable is released throughout the turnaround and data window of a read. MDC holds still while the port is disabled. The command half of the readback word stays fixed during a frame. Only the bench scenarios can show the rest: the exact bit order of the frame, the busy time for each division ratio, the PHY data landing in the readback word, and that commands written while busy or disabled are dropped. The bench does this with a small PHY model that answers reads on the falling MDC edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned PRE_LEN   = 32;
   localparam int unsigned FRAME_LEN = PRE_LEN + WORD_W;
   localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned DATA_W    = 16;
   localparam int unsigned OP_HI     = 29;
   localparam int unsigned OP_LO     = 28;
   // frame position of the first turnaround bit (word bit 17)
   localparam int unsigned TA_START  = PRE_LEN + (WORD_W - 1 - 17);
   // frame position of the first read data bit (word bit 15)
   localparam int unsigned RD_START  = FRAME_LEN - DATA_W;

   typedef enum logic [1:0] {
      OPC_RSVD0 = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_RSVD3 = 2'b11
   } mdio_opc_e;

   function automatic int unsigned div_for_sel(input logic [SEL_W-1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return 48;
      endcase
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] div_sel,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);

   localparam int unsigned NSEL = 1 << SEL_W;

   if ((1 << CNT_W) < (div_for_sel(SEL_W'(NSEL - 1)) / 2)) begin : g_cnt_too_small
      $error("CNT_W cannot hold the largest MDC half period");
   end

   logic [CNT_W-1:0] half_tab [NSEL];

   for (genvar s = 0; s < NSEL; s++) begin : g_half_tab
      assign half_tab[s] = CNT_W'(div_for_sel(SEL_W'(s)) / 2 - 1);
   end

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic [CNT_W-1:0] half_m1;
   logic             tick;

   assign half_m1  = half_tab[div_sel];
   assign tick     = run && (cnt_q == half_m1);
   assign rise_evt = tick && !mdc_q;
   assign fall_evt = tick && mdc_q;
   assign mdc      = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc_q <= !mdc_q;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R9
   frozen_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
   import mdio_mgmt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] wdata,
   input  logic              shift_en,
   input  logic              sdin,
   input  logic              busy,
   output logic [WORD_W-1:0] word
);

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= wdata;
      end else if (shift_en) begin
         word_q[DATA_W-1:0] <= {word_q[DATA_W-2:0], sdin};
      end
   end

   assign word = word_q;

   // R8
   cmd_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(word_q[WORD_W-1:DATA_W]));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              rd_op,
   input  logic [WORD_W-1:0] word,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              sample_evt
);

   localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_START);
   localparam logic [IDX_W-1:0] RD_IDX   = IDX_W'(RD_START);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   logic             o_q;
   logic             oe_q;
   logic [IDX_W-1:0] idx_nx;

   function automatic logic bit_at(input logic [IDX_W-1:0] i,
                                   input logic [WORD_W-1:0] w);
      int unsigned pos;
      if (i < PRE_IDX) return 1'b1;
      pos = WORD_W - 1 - (int'(i) - PRE_LEN);
      return w[pos];
   endfunction

   function automatic logic drive_at(input logic [IDX_W-1:0] i, input logic rd);
      return !(rd && (i >= TA_IDX));
   endfunction

   assign idx_nx = idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
         o_q    <= 1'b1;
         oe_q   <= 1'b0;
      end else if (accept) begin
         idx_q  <= '0;
         busy_q <= 1'b1;
         o_q    <= 1'b1;
         oe_q   <= 1'b1;
      end else if (busy_q && fall_evt) begin
         if (idx_q == LAST_IDX) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
            o_q    <= 1'b1;
            oe_q   <= 1'b0;
         end else begin
            idx_q <= idx_nx;
            o_q   <= bit_at(idx_nx, word);
            oe_q  <= drive_at(idx_nx, rd_op);
         end
      end
   end

   assign busy       = busy_q;
   assign mdio_o     = o_q;
   assign mdio_oe    = oe_q;
   assign sample_evt = busy_q && rise_evt && rd_op && (idx_q >= RD_IDX);

   // R4
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rd_op && (idx_q >= TA_IDX)) |-> !oe_q);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        port_en,
   input  logic [1:0]  div_sel,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_wdata,
   output logic [31:0] cmd_rdata,
   output logic        mgmt_idle,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   if (WORD_W != 32) begin : g_bad_word
      $error("command word must be 32 bits wide");
   end

   logic              busy;
   logic              accept;
   logic              run;
   logic              rise_evt;
   logic              fall_evt;
   logic              sample_evt;
   logic              rd_op;
   logic [WORD_W-1:0] word;

   assign accept = cmd_wr && port_en && !busy;
   assign run    = busy && port_en;
   assign rd_op  = (word[OP_HI:OP_LO] == OPC_READ);

   mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .clr      (accept),
      .div_sel  (div_sel),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_cmd_reg u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .wdata    (cmd_wdata),
      .shift_en (sample_evt),
      .sdin     (mdio_i),
      .busy     (busy),
      .word     (word)
   );

   mdio_frame_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .rise_evt   (rise_evt),
      .fall_evt   (fall_evt),
      .rd_op      (rd_op),
      .word       (word),
      .busy       (busy),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .sample_evt (sample_evt)
   );

   assign cmd_rdata = word;
   assign mgmt_idle = !busy;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_idle |-> (!mdc && !mdio_oe));

   // R2
   data_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> !mdc);

   // R9
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> ($stable(mdc) && $stable(mgmt_idle)));

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b1;
   logic [1:0]  div_sel = 2'b00;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        mgmt_idle;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i;

   int checks = 0;
   int errors = 0;

   always #4 clk = !clk;

   mdio_mgmt_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .div_sel   (div_sel),
      .cmd_wr    (cmd_wr),
      .cmd_wdata (cmd_wdata),
      .cmd_rdata (cmd_rdata),
      .mgmt_idle (mgmt_idle),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   // PHY model: bit counter advances on falling MDC, answers with resp
   int          bitcnt = 0;
   int          base = 0;
   int          rel;
   logic [15:0] phy_resp = '0;
   logic [63:0] cap_o = '0;
   logic [63:0] cap_oe = '0;

   always @(negedge mdc) bitcnt <= bitcnt + 1;
   always @(posedge mdc) begin
      cap_o  <= {cap_o[62:0], mdio_o};
      cap_oe <= {cap_oe[62:0], mdio_oe};
   end

   assign rel    = bitcnt - base;
   assign mdio_i = (rel >= 48 && rel < 64) ? phy_resp[63 - rel] : 1'b1;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int div_of(input logic [1:0] s);
      case (s)
         2'd0: return 8;
         2'd1: return 16;
         2'd2: return 32;
         default: return 48;
      endcase
   endfunction

   function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] pa,
                                          input logic [4:0] ra, input logic [15:0] d);
      return {2'b01, op, pa, ra, 2'b10, d};
   endfunction

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (!mgmt_idle && cyc < 10000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      cmd_wdata = w;
      cmd_wr    = 1'b1;
      @(negedge clk);
      cmd_wr    = 1'b0;
   endtask

   task automatic check_frame(input string req, input logic [31:0] w);
      logic [63:0] exp_o;
      logic [63:0] exp_oe;
      exp_o  = {32'hFFFF_FFFF, w};
      exp_oe = (w[29:28] == 2'b10) ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
      chk({req, " frame oe"}, cap_oe, exp_oe);
      chk({req, " frame bits"}, cap_o & exp_oe, exp_o & exp_oe);
   endtask

   // vector: sel, op, phy addr, reg addr, write data, phy response
   localparam int NV = 5;
   localparam logic [45:0] VEC [NV] = '{
      {2'b00, 2'b01, 5'd5,  5'd4,  16'h1234, 16'h0000},
      {2'b00, 2'b10, 5'd1,  5'd1,  16'h0000, 16'h796D},
      {2'b01, 2'b10, 5'd31, 5'd2,  16'h0000, 16'hA5C3},
      {2'b10, 2'b10, 5'd16, 5'd31, 16'h0000, 16'h8001},
      {2'b11, 2'b01, 5'd0,  5'd0,  16'hFFFF, 16'h0000}
   };

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      logic [31:0] w;
      logic [31:0] wa;
      logic [31:0] wb;
      logic        mdc_seen;
      logic        moved;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 idle", 64'(mgmt_idle), 64'd1);
      chk("R1 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
      chk("R1 rdata", 64'(cmd_rdata), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R6 R7 R10
      for (int i = 0; i < NV; i++) begin
         div_sel  = VEC[i][45:44];
         w        = mk_cmd(VEC[i][43:42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16]);
         phy_resp = VEC[i][15:0];
         base     = bitcnt;
         issue(w);
         wait_idle(cyc);
         chk("R6 R7 busy cycles", 64'(cyc), 64'(64 * div_of(VEC[i][45:44])));
         check_frame(w[29:28] == 2'b10 ? "R2 R4" : "R2 R3", w);
         if (w[29:28] == 2'b10)
            chk("R5 read data", 64'(cmd_rdata), 64'({w[31:16], VEC[i][15:0]}));
         else
            chk("R10 readback", 64'(cmd_rdata), 64'(w));
      end

      // R8: second command during busy is ignored
      div_sel = 2'b00;
      wa = mk_cmd(2'b01, 5'd3, 5'd9, 16'hBEEF);
      wb = mk_cmd(2'b10, 5'd7, 5'd7, 16'h0000);
      base = bitcnt;
      issue(wa);
      repeat (40) @(negedge clk);
      cmd_wdata = wb;
      cmd_wr = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      wait_idle(cyc);
      chk("R8 busy cycles unchanged", 64'(cyc + 41), 64'(64 * 8));
      chk("R8 readback", 64'(cmd_rdata), 64'(wa));
      check_frame("R8", wa);

      // R9: strobe with port disabled is ignored
      port_en = 1'b0;
      issue(wb);
      chk("R9 idle while disabled", 64'(mgmt_idle), 64'd1);
      repeat (600) @(negedge clk);
      chk("R9 readback kept", 64'(cmd_rdata), 64'(wa));

      // R9: frame freezes while disabled and resumes
      port_en  = 1'b1;
      phy_resp = 16'h3C5A;
      base     = bitcnt;
      issue(wb);
      repeat (100) @(negedge clk);
      port_en  = 1'b0;
      @(negedge clk);
      mdc_seen = mdc;
      moved    = 1'b0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (mdc !== mdc_seen) moved = 1'b1;
      end
      chk("R9 mdc frozen", 64'(moved), 64'd0);
      chk("R9 still busy", 64'(mgmt_idle), 64'd0);
      port_en = 1'b1;
      wait_idle(cyc);
      check_frame("R9 R4", wb);
      chk("R9 R5 read data", 64'(cmd_rdata), 64'({wb[31:16], 16'h3C5A}));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule